// File: doc/BRIEF.md
# Dual-Mode Clock-Domain-Crossing FIFO

This block is a first-in first-out buffer of 4096 words of 18 bits. It has a write port and a read port, and each runs on its own free-running clock. The two clocks may be unrelated or may be the same net. A word is accepted on a rising write-clock edge when the write enable is high. Words leave on rising read-clock edges.

The `fwft_i` input picks the read behaviour. In standard mode a word reaches the output register only through an explicit read. In fall-through mode the oldest stored word is moved into the output register without any request. The read enable then acts as an acknowledgement that the presented word has been taken. The two fixed status outputs change meaning with the mode: they report empty/full in standard mode and output-ready/input-ready in fall-through mode.

A half-full flag is also provided, along with two programmable threshold flags. The thresholds are written over the data bus while `load_i` is held high. A selector alternates between the almost-empty threshold and the almost-full threshold on each write-enabled cycle. `oe_i` gates the data output to zero.

Top module: `dual_mode_fifo`

## Requirements
- R1: After reset (`rst_ni` low), the block shows:
  - no stored words;
  - `rdata_o` = 0;
  - `half_o` = 0, `afull_o` = 0 and `aempty_o` = 1;
  - in standard mode `empty_or_o` = 1 and `full_ir_o` = 0;
  - in fall-through mode `empty_or_o` = 0 and `full_ir_o` = 1.
- R2: In standard mode (`fwft_i` = 0), a rising read edge with `ren_i` = 1 and storage non-empty moves the oldest word into the output register, in write order. In every other cycle the output register holds its value.
- R3: A write attempted while storage holds 4096 words is dropped. A read attempted while storage is empty is dropped. Neither one changes the stored contents or their order.
- R4: In fall-through mode (`fwft_i` = 1), a word written into an empty FIFO is presented on `rdata_o`, with `empty_or_o` = 1, after the third read edge that follows the accepting write edge, with no read enable. While `ren_i` is low, the presented word and `empty_or_o` hold. A read edge with `ren_i` = 1 either advances to the next word or, if none is waiting, clears `empty_or_o`.
- R5: In standard mode, `empty_or_o` = 1 means storage is empty and `full_ir_o` = 1 means storage is full. In fall-through mode, `empty_or_o` = 1 means a valid word is presented and `full_ir_o` = 1 means storage is not full.
- R6: `half_o` = 1 exactly while the write-side word count is greater than 2048.
- R7: Two threshold flags:
  - `aempty_o` = 1 while the read-side count of words in storage is less than or equal to the almost-empty threshold. In fall-through mode the presented word is not counted.
  - `afull_o` = 1 while 4096 minus the write-side count is less than or equal to the almost-full threshold.
- R8: While `load_i` = 1, each cycle with `wen_i` = 1 writes `wdata_i[11:0]` into a threshold and stores no data word. The target alternates: almost-empty first, then almost-full, then back to almost-empty. A cycle with `load_i` = 0 returns the selector to almost-empty. Reset sets both thresholds to 127.
- R9: While `oe_i` = 0, `rdata_o` is 0. The output register itself is not affected.
- R10: With the default two synchroniser stages, the read side sees an accepted write on the second read edge after it. The write side sees a read on the second write edge after it. Each count, and the flags taken from it, changes at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-side clock |
| rclk_i | input | 1 | Read-side clock |
| rst_ni | input | 1 | Asynchronous reset, active low, both sides |
| fwft_i | input | 1 | 1 = fall-through mode, 0 = standard mode |
| wen_i | input | 1 | Write enable |
| wdata_i | input | 18 | Write data; bits 11:0 carry a threshold while loading |
| load_i | input | 1 | Threshold load mode |
| ren_i | input | 1 | Read enable / acknowledge |
| oe_i | input | 1 | Data output gate |
| rdata_o | output | 18 | Output data |
| empty_or_o | output | 1 | Empty (standard) or output ready (fall-through) |
| full_ir_o | output | 1 | Full (standard) or input ready (fall-through) |
| half_o | output | 1 | More than half the depth in use |
| aempty_o | output | 1 | Count at or below the almost-empty threshold |
| afull_o | output | 1 | Free space at or below the almost-full threshold |

## Verification
The case of interest is a write and a read landing on the same edge. This matters most near the empty and full boundaries, where the two-edge-late view of the other side decides whether each one is accepted. Both clocks are driven from one net. Random traffic with independent write and read enables then produces many coincident push/pop cycles, both around an empty store and with storage held near 4096 words. On every clock, the data, the fixed flags and the threshold flags are compared against a queue model that tracks the delayed counts of each side.

// File: rtl/dual_mode_fifo_pkg.sv
package dual_mode_fifo_pkg;

  typedef enum logic {
    SEL_AE = 1'b0,
    SEL_AF = 1'b1
  } ofs_sel_e;

  function automatic logic [31:0] bin2gray(logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/dual_mode_fifo_ram.sv
module dual_mode_fifo_ram #(
  parameter int DW = 18,
  parameter int AW = 12
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dual_mode_fifo_sync.sv
module dual_mode_fifo_sync #(
  parameter int W      = 13,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dual_mode_fifo_wr.sv
module dual_mode_fifo_wr
  import dual_mode_fifo_pkg::*;
#(
  parameter int AW         = 12,
  parameter int AE_DEFAULT = 127,
  parameter int AF_DEFAULT = 127
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          wen_i,
  input  logic          load_i,
  input  logic [AW-1:0] ofs_i,
  input  logic [AW:0]   rgray_s_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o,
  output logic [AW:0]   wptr_o,
  output logic          full_o,
  output logic          half_o,
  output logic          afull_o,
  output logic [AW-1:0] pae_o
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

  logic [PW-1:0] wptr_q, wgray_q, rbin_s, wcount, free_cnt;
  logic [AW-1:0] pae_q, paf_q;
  ofs_sel_e      sel_q;
  logic          push;

  assign rbin_s   = PW'(gray2bin(32'(rgray_s_i)));
  assign wcount   = wptr_q - rbin_s;
  assign free_cnt = DEPTH_P - wcount;
  assign full_o   = (wcount == DEPTH_P);
  assign half_o   = (wcount > (DEPTH_P >> 1));
  assign afull_o  = (free_cnt <= {1'b0, paf_q});
  assign push     = wen_i && !load_i && !full_o;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      wgray_q <= '0;
      pae_q   <= AW'(AE_DEFAULT);
      paf_q   <= AW'(AF_DEFAULT);
      sel_q   <= SEL_AE;
    end else begin
      if (push) begin
        wptr_q  <= wptr_q + 1'b1;
        wgray_q <= PW'(bin2gray(32'(wptr_q + 1'b1)));
      end
      if (!load_i) begin
        sel_q <= SEL_AE;
      end else if (wen_i) begin
        if (sel_q == SEL_AE) pae_q <= ofs_i;
        else                 paf_q <= ofs_i;
        sel_q <= (sel_q == SEL_AE) ? SEL_AF : SEL_AE;
      end
    end
  end

  assign we_o    = push;
  assign waddr_o = wptr_q[AW-1:0];
  assign wgray_o = wgray_q;
  assign wptr_o  = wptr_q;
  assign pae_o   = pae_q;
endmodule

// File: rtl/dual_mode_fifo_rd.sv
module dual_mode_fifo_rd
  import dual_mode_fifo_pkg::*;
#(
  parameter int DW = 18,
  parameter int AW = 12
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic          ren_i,
  input  logic [AW:0]   wgray_s_i,
  input  logic [AW-1:0] pae_i,
  input  logic [DW-1:0] ram_rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic [AW:0]   rptr_o,
  output logic          empty_o,
  output logic          aempty_o,
  output logic          valid_o,
  output logic [DW-1:0] dout_o
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rptr_q, rgray_q, wbin_s, rcount;
  logic [DW-1:0] dout_q;
  logic          valid_q, pop;

  assign wbin_s   = PW'(gray2bin(32'(wgray_s_i)));
  assign rcount   = wbin_s - rptr_q;
  assign empty_o  = (rcount == '0);
  assign aempty_o = (rcount <= {1'b0, pae_i});
  // fall-through refills the output stage whenever it is free or being taken
  assign pop = !empty_o && (fwft_i ? (!valid_q || ren_i) : ren_i);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      rgray_q <= '0;
      dout_q  <= '0;
      valid_q <= 1'b0;
    end else if (pop) begin
      rptr_q  <= rptr_q + 1'b1;
      rgray_q <= PW'(bin2gray(32'(rptr_q + 1'b1)));
      dout_q  <= ram_rdata_i;
      valid_q <= 1'b1;
    end else if (ren_i) begin
      valid_q <= 1'b0;
    end
  end

  assign raddr_o = rptr_q[AW-1:0];
  assign rgray_o = rgray_q;
  assign rptr_o  = rptr_q;
  assign valid_o = valid_q;
  assign dout_o  = dout_q;
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
  parameter int DW          = 18,
  parameter int AW          = 12,
  parameter int SYNC_STAGES = 2,
  parameter int AE_DEFAULT  = 127,
  parameter int AF_DEFAULT  = 127
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic          wen_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          load_i,
  input  logic          ren_i,
  input  logic          oe_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_or_o,
  output logic          full_ir_o,
  output logic          half_o,
  output logic          aempty_o,
  output logic          afull_o
);
  localparam int PW = AW + 1;

  logic          ram_we, ram_full, ram_empty, out_valid;
  logic [AW-1:0] waddr, raddr, pae_ofs;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s, wptr_bin, rptr_bin;
  logic [DW-1:0] ram_rdata, dout;

  dual_mode_fifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk_i (wclk_i),
    .we_i   (ram_we),
    .waddr_i(waddr),
    .wdata_i(wdata_i),
    .raddr_i(raddr),
    .rdata_o(ram_rdata)
  );

  dual_mode_fifo_wr #(.AW(AW), .AE_DEFAULT(AE_DEFAULT), .AF_DEFAULT(AF_DEFAULT)) u_wr (
    .wclk_i   (wclk_i),
    .rst_ni   (rst_ni),
    .wen_i    (wen_i),
    .load_i   (load_i),
    .ofs_i    (wdata_i[AW-1:0]),
    .rgray_s_i(rgray_s),
    .we_o     (ram_we),
    .waddr_o  (waddr),
    .wgray_o  (wgray),
    .wptr_o   (wptr_bin),
    .full_o   (ram_full),
    .half_o   (half_o),
    .afull_o  (afull_o),
    .pae_o    (pae_ofs)
  );

  dual_mode_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .d_i   (wgray),
    .q_o   (wgray_s)
  );

  dual_mode_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .d_i   (rgray),
    .q_o   (rgray_s)
  );

  dual_mode_fifo_rd #(.DW(DW), .AW(AW)) u_rd (
    .rclk_i     (rclk_i),
    .rst_ni     (rst_ni),
    .fwft_i     (fwft_i),
    .ren_i      (ren_i),
    .wgray_s_i  (wgray_s),
    .pae_i      (pae_ofs),
    .ram_rdata_i(ram_rdata),
    .raddr_o    (raddr),
    .rgray_o    (rgray),
    .rptr_o     (rptr_bin),
    .empty_o    (ram_empty),
    .aempty_o   (aempty_o),
    .valid_o    (out_valid),
    .dout_o     (dout)
  );

  assign empty_or_o = fwft_i ? out_valid : ram_empty;
  assign full_ir_o  = fwft_i ? !ram_full : ram_full;
  assign rdata_o    = oe_i ? dout : '0;
endmodule

// File: rtl/dual_mode_fifo_chk.sv
module dual_mode_fifo_chk #(
  parameter int DW = 18,
  parameter int PW = 13
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          fwft_i,
  input logic          wen_i,
  input logic          ren_i,
  input logic          load_i,
  input logic          ram_full,
  input logic          ram_empty,
  input logic          out_valid,
  input logic          afull_o,
  input logic [PW-1:0] wptr_bin,
  input logic [PW-1:0] rptr_bin,
  input logic [DW-1:0] dout
);
  assert_full_drop_R3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (ram_full && wen_i) |=> $stable(wptr_bin));

  assert_empty_drop_R3: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    ram_empty |=> $stable(rptr_bin));

  assert_rptr_step_R2: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rptr_bin == $past(rptr_bin)) || (rptr_bin == $past(rptr_bin) + 1'b1));

  assert_fwft_hold_R4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (fwft_i && out_valid && !ren_i) |=> (out_valid && $stable(dout)));

  assert_load_no_store_R8: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (load_i && wen_i) |=> $stable(wptr_bin));

  assert_afull_at_full_R7: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ram_full |-> afull_o);
endmodule

bind dual_mode_fifo dual_mode_fifo_chk #(.DW(DW), .PW(PW)) u_chk (
  .wclk_i   (wclk_i),
  .rclk_i   (rclk_i),
  .rst_ni   (rst_ni),
  .fwft_i   (fwft_i),
  .wen_i    (wen_i),
  .ren_i    (ren_i),
  .load_i   (load_i),
  .ram_full (ram_full),
  .ram_empty(ram_empty),
  .out_valid(out_valid),
  .afull_o  (afull_o),
  .wptr_bin (wptr_bin),
  .rptr_bin (rptr_bin),
  .dout     (dout)
);

// File: tb/dual_mode_fifo_test.sv
module dual_mode_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4096;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fwft_i = 1'b0, wen_i = 1'b0, load_i = 1'b0, ren_i = 1'b0, oe_i = 1'b1;
  logic [17:0] wdata_i = '0;
  logic [17:0] rdata_o;
  logic        empty_or_o, full_ir_o, half_o, aempty_o, afull_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_mode_fifo uut (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_ni), .fwft_i(fwft_i),
    .wen_i(wen_i), .wdata_i(wdata_i), .load_i(load_i), .ren_i(ren_i),
    .oe_i(oe_i), .rdata_o(rdata_o), .empty_or_o(empty_or_o),
    .full_ir_o(full_ir_o), .half_o(half_o), .aempty_o(aempty_o), .afull_o(afull_o)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  // reference model: totals of accepted writes/reads plus two-edge-late copies
  int w_tot, w_p1, w_p2, r_tot, r_p1, r_p2, pae, paf;
  bit sel, ov, fwft_m, oe_m;
  logic [17:0] dout_m;
  logic [17:0] q[$];

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset(bit mode);
    w_tot = 0; w_p1 = 0; w_p2 = 0; r_tot = 0; r_p1 = 0; r_p2 = 0;
    pae = 127; paf = 127; sel = 0; ov = 0; fwft_m = mode; dout_m = '0;
    q.delete();
  endtask

  task automatic model_edge(bit wen, logic [17:0] wd, bit ren, bit ld);
    int wc = w_tot - r_p2;
    int rc = w_p2 - r_tot;
    bit wa = 0, ra = 0;
    if (ld) begin
      if (wen) begin
        if (!sel) pae = int'(wd[11:0]); else paf = int'(wd[11:0]);
        sel = !sel;
      end
    end else begin
      sel = 0;
      wa = wen && (wc < DEPTH);
    end
    if (fwft_m) begin
      if (rc > 0 && (!ov || ren)) begin ra = 1; dout_m = q.pop_front(); ov = 1; end
      else if (ren) ov = 0;
    end else if (ren && rc > 0) begin
      ra = 1; dout_m = q.pop_front();
    end
    if (wa) q.push_back(wd);
    w_p2 = w_p1; w_p1 = w_tot; w_tot += int'(wa);
    r_p2 = r_p1; r_p1 = r_tot; r_tot += int'(ra);
  endtask

  task automatic check_all();
    int wc = w_tot - r_p2;
    int rc = w_p2 - r_tot;
    if (!oe_m) chk("R9 gated data", int'(rdata_o), 0);
    else if (fwft_m) chk("R4 fall-through data", int'(rdata_o), int'(dout_m));
    else chk("R2 standard data", int'(rdata_o), int'(dout_m));
    chk("R5 empty/ready flag", int'(empty_or_o), fwft_m ? int'(ov) : int'(rc == 0));
    chk("R5 full/input-ready flag", int'(full_ir_o), fwft_m ? int'(wc != DEPTH) : int'(wc == DEPTH));
    chk("R6 half flag", int'(half_o), int'(wc > DEPTH/2));
    chk("R7 almost-empty flag", int'(aempty_o), int'(rc <= pae));
    chk("R7 almost-full flag", int'(afull_o), int'((DEPTH - wc) <= paf));
  endtask

  // called at a negedge; drives for the next edge, checks at the following negedge
  task automatic cyc(bit wen, logic [17:0] wd, bit ren, bit ld, bit oe);
    wen_i = wen; wdata_i = wd; ren_i = ren; load_i = ld; oe_i = oe;
    model_edge(wen, wd, ren, ld);
    oe_m = oe;
    @(negedge clk);
    check_all();
  endtask

  task automatic do_reset(bit mode);
    rst_ni = 1'b0; fwft_i = mode; wen_i = 0; ren_i = 0; load_i = 0; oe_i = 1; oe_m = 1;
    repeat (3) @(negedge clk);
    model_reset(mode);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 reset empty/ready", int'(empty_or_o), mode ? 0 : 1);
    chk("R1 reset full/input-ready", int'(full_ir_o), mode ? 1 : 0);
    chk("R1 reset half", int'(half_o), 0);
    chk("R1 reset almost-empty", int'(aempty_o), 1);
    chk("R1 reset almost-full", int'(afull_o), 0);
    chk("R1 reset data", int'(rdata_o), 0);
    check_all();
  endtask

  initial begin
    // ---- standard mode ----
    do_reset(1'b0);
    cyc(1, 18'h2a5a5, 0, 0, 1);
    chk("R10 empty after write edge", int'(empty_or_o), 1);
    cyc(0, 0, 0, 0, 1);
    chk("R10 empty one edge later", int'(empty_or_o), 1);
    cyc(0, 0, 0, 0, 1);
    chk("R10 seen two edges later", int'(empty_or_o), 0);
    chk("R2 no read without enable", int'(rdata_o), 0);
    cyc(1, 18'h00011, 0, 0, 1);
    cyc(1, 18'h3ffff, 0, 0, 1);
    repeat (3) cyc(0, 0, 0, 0, 1);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 1);
    chk("R2 last word read", int'(rdata_o), 'h3ffff);
    repeat (3) cyc(0, 0, 1, 0, 1);
    chk("R3 read on empty keeps output", int'(rdata_o), 'h3ffff);
    // threshold load: AE=5, AF=8, AE=3 (wrap), drop load, AE=6
    cyc(1, 18'd5, 0, 1, 1);
    cyc(1, 18'd8, 0, 1, 1);
    cyc(1, 18'd3, 0, 1, 1);
    cyc(0, 0, 0, 0, 1);
    cyc(1, 18'd6, 0, 1, 1);
    repeat (3) cyc(0, 0, 0, 0, 1);
    chk("R8 load stores no data", int'(empty_or_o), 1);
    for (int i = 0; i < 8; i++) cyc(1, 18'(i + 100), 0, 0, 1);
    repeat (2) cyc(0, 0, 0, 0, 1);
    chk("R8 almost-empty uses loaded 6", int'(aempty_o), 0);
    // fill past full
    for (int i = 0; i < DEPTH; i++) cyc(1, 18'(i * 7 + 3), 0, 0, 1);
    repeat (3) cyc(0, 0, 0, 0, 1);
    chk("R3 full after overfill", int'(full_ir_o), 1);
    chk("R8 almost-full at full", int'(afull_o), 1);
    // coincident traffic near full, then drain
    for (int i = 0; i < 1500; i++) cyc(1'($urandom), 18'($urandom), 1'($urandom), 0, 1'($urandom_range(0, 3) != 0));
    for (int i = 0; i < DEPTH + 10; i++) cyc(0, 0, 1, 0, 1);
    chk("R3 drained to empty", int'(empty_or_o), 1);
    for (int i = 0; i < 2000; i++) cyc(1'($urandom), 18'($urandom), 1'($urandom), 0, 1'($urandom_range(0, 3) != 0));

    // ---- fall-through mode ----
    do_reset(1'b1);
    cyc(1, 18'h1c3c3, 0, 0, 1);
    chk("R4 not ready after write edge", int'(empty_or_o), 0);
    cyc(0, 0, 0, 0, 1);
    chk("R4 not ready edge 1", int'(empty_or_o), 0);
    cyc(0, 0, 0, 0, 1);
    chk("R4 not ready edge 2", int'(empty_or_o), 0);
    cyc(0, 0, 0, 0, 1);
    chk("R4 ready on edge 3", int'(empty_or_o), 1);
    chk("R4 word presented", int'(rdata_o), 'h1c3c3);
    cyc(0, 0, 0, 0, 0);
    chk("R9 output gated", int'(rdata_o), 0);
    cyc(0, 0, 0, 0, 1);
    chk("R9 register kept while gated", int'(rdata_o), 'h1c3c3);
    cyc(0, 0, 1, 0, 1);
    chk("R4 ready clears on last take", int'(empty_or_o), 0);
    for (int i = 0; i < 3000; i++) cyc(1'($urandom), 18'($urandom), 1'($urandom), 0, 1'($urandom_range(0, 3) != 0));
    for (int i = 0; i < DEPTH + 20; i++) cyc(1, 18'($urandom), 0, 0, 1);
    chk("R5 input-ready low when full", int'(full_ir_o), 0);
    for (int i = 0; i < 2000; i++) cyc(1'($urandom), 18'($urandom), 1'($urandom_range(0, 2) == 0), 0, 1);
    for (int i = 0; i < DEPTH + 20; i++) cyc(0, 0, 1, 0, 1);
    chk("R5 ready low when drained", int'(empty_or_o), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule